// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It divides the oscillator clock down to a count rate and runs a fixed-length measurement cycle of three phases. In auto-zero the integrator is nulled. In signal integrate the unknown input is integrated for a fixed number of counts. In reference de-integrate a reference of opposite sign runs the integrator back to zero while a decade counter measures how long that takes. The analog integrator, the reference switches and the comparator stay outside the block. Only the comparator's one-bit decision comes in, and the phase enables plus a reference-direction select go out.

The cycle length never depends on the input. De-integrate stops at the first count where the comparator shows that the integrator has crossed zero. The counts that de-integrate leaves unused are added to the following auto-zero phase. At the end of de-integrate the decade count and the sign are copied into a display register. That register keeps its value for the whole next cycle. If the integrator has not crossed zero when the de-integrate window closes, the register holds an overrange pattern instead of a number.

Top module: `dsadc_seq`

## Requirements
- R1: One count lasts exactly PRESCALE oscillator clocks. Signal integrate lasts exactly INT_COUNTS counts, which is INT_COUNTS*PRESCALE clocks.
- R2: Exactly one of `phase_az`, `phase_int` and `phase_deint` is high at all times. The phases always follow the order auto-zero, then integrate, then de-integrate, then auto-zero again. Reset leaves only `phase_az` high. The first auto-zero after reset lasts CYCLE_COUNTS-INT_COUNTS-DEINT_MAX counts.
- R3: Each measurement cycle, measured from one rise of `phase_int` to the next, lasts CYCLE_COUNTS*PRESCALE clocks whatever the input.
- R4: `comp_i` high means the integrator output is above zero. The comparator is sampled on the last integrate count, and `ref_neg` becomes its inverse: 1 marks a negative input and selects the reference direction that raises the integrator. `ref_neg` is held for the whole of de-integrate, and `disp_neg` latches it.
- R5: De-integrate ends on the first count at which `comp_i` equals `ref_neg`, after k counts have been accumulated (k < DEINT_MAX). It then lasts (k+1)*PRESCALE clocks, and k is latched into the display with `disp_over` = 0.
- R6: The reading is binary-coded decimal. Digit d sits in `disp_bcd[4d+3:4d]`, with digit 0 the units, and every digit of a reading is 0 to 9.
- R7: If no crossing has been seen after DEINT_MAX counts, de-integrate lasts exactly DEINT_MAX*PRESCALE clocks. `disp_over` is then set and every nibble of `disp_bcd` reads 4'hF.
- R8: Reset clears `disp_bcd`, `disp_neg` and `disp_over` to 0. The display outputs change only on the clock edge that ends de-integrate and are held through the rest of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_i | input | 1 | Comparator decision, 1 = integrator above zero |
| phase_az | output | 1 | Auto-zero phase enable |
| phase_int | output | 1 | Signal-integrate phase enable |
| phase_deint | output | 1 | Reference de-integrate phase enable |
| ref_neg | output | 1 | Reference direction for de-integrate, 1 = input was negative |
| disp_bcd | output | 4*DIGITS | Latched BCD reading, units digit in the low nibble |
| disp_neg | output | 1 | Latched minus indication |
| disp_over | output | 1 | Latched overrange flag |

## Verification
The bench drives the comparator from an integrator model that follows the phase enables and `ref_neg`. Inputs are given in half-count steps of both signs, so each input has exactly one correct reading. It sweeps every magnitude from one count up through the last in-range reading, exactly full scale, and one count beyond. This separates an off-by-one in crossing detection from a polarity or reference-direction error, and it places the overrange boundary at exactly DEINT_MAX. For every input it also measures the integrate, de-integrate and auto-zero lengths, which shows that the cycle stays fixed while the de-integrate share changes.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

   typedef enum logic [1:0] {
      PH_AZ    = 2'd0,
      PH_INT   = 2'd1,
      PH_DEINT = 2'd2
   } phase_e;

   function automatic int pow10(input int n);
      int r;
      r = 1;
      for (int i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction

endpackage

// File: rtl/dsadc_prescale.sv
module dsadc_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         logic [W-1:0] cnt;
         assign tick = (cnt == W'(DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)    cnt <= '0;
            else if (tick) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dsadc_bcd_count.sv
module dsadc_bcd_count #(
   parameter int DIGITS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  inc,
   output logic [4*DIGITS-1:0]   value
);
   logic [DIGITS:0] carry;
   assign carry[0] = inc;

   generate
      for (genvar d = 0; d < DIGITS; d++) begin : g_digit
         logic [3:0] dig;
         assign carry[d+1]   = carry[d] & (dig == 4'd9);
         assign value[4*d+:4] = dig;
         always_ff @(posedge clk) begin
            if (!rst_n)        dig <= 4'd0;
            else if (clr)      dig <= 4'd0;
            else if (carry[d]) dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
         end
      end
   endgenerate
endmodule

// File: rtl/dsadc_phase_ctl.sv
module dsadc_phase_ctl
   import dsadc_pkg::*;
#(
   parameter int INT_COUNTS   = 1000,
   parameter int DEINT_MAX    = 2000,
   parameter int CYCLE_COUNTS = 4000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  logic   comp_i,
   output phase_e phase,
   output logic   ref_neg,
   output logic   cnt_clr,
   output logic   cnt_inc,
   output logic   lat_ok,
   output logic   lat_ovr
);
   localparam int CW       = $clog2(CYCLE_COUNTS);
   localparam int LAST     = CYCLE_COUNTS - 1;
   localparam int INT_END  = INT_COUNTS - 1;
   localparam int DE_END   = INT_COUNTS + DEINT_MAX - 1;
   localparam int AZ_ENTRY = INT_COUNTS + DEINT_MAX;

   logic [CW-1:0] pos;
   phase_e        nxt;
   logic          crossed;

   assign crossed = (comp_i == ref_neg);

   always_comb begin
      nxt     = phase;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      lat_ok  = 1'b0;
      lat_ovr = 1'b0;
      if (tick) begin
         case (phase)
            PH_AZ: begin
               if (pos == CW'(LAST)) nxt = PH_INT;
            end
            PH_INT: begin
               if (pos == CW'(INT_END)) begin
                  nxt     = PH_DEINT;
                  cnt_clr = 1'b1;
               end
            end
            PH_DEINT: begin
               if (crossed) begin
                  lat_ok = 1'b1;
                  nxt    = PH_AZ;
               end else begin
                  cnt_inc = 1'b1;
                  if (pos == CW'(DE_END)) begin
                     lat_ovr = 1'b1;
                     nxt     = PH_AZ;
                  end
               end
            end
            default: nxt = PH_AZ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_AZ;
         pos     <= CW'(AZ_ENTRY);
         ref_neg <= 1'b0;
      end else begin
         phase <= nxt;
         if (tick) pos <= (pos == CW'(LAST)) ? '0 : pos + 1'b1;
         if (tick && phase == PH_INT && pos == CW'(INT_END)) ref_neg <= ~comp_i;
      end
   end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
   import dsadc_pkg::*;
#(
   parameter int PRESCALE     = 4,
   parameter int INT_COUNTS   = 1000,
   parameter int DEINT_MAX    = 2000,
   parameter int CYCLE_COUNTS = 4000,
   parameter int DIGITS       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                comp_i,
   output logic                phase_az,
   output logic                phase_int,
   output logic                phase_deint,
   output logic                ref_neg,
   output logic [4*DIGITS-1:0] disp_bcd,
   output logic                disp_neg,
   output logic                disp_over
);
   localparam logic [4*DIGITS-1:0] BLANK = {DIGITS{4'hF}};

   generate
      if (PRESCALE < 1) begin : g_chk_pre
         $error("PRESCALE must be at least 1");
      end
      if (INT_COUNTS < 1 || DEINT_MAX < 2) begin : g_chk_len
         $error("integrate and de-integrate windows too short");
      end
      if (CYCLE_COUNTS <= INT_COUNTS + DEINT_MAX) begin : g_chk_cyc
         $error("cycle leaves no room for auto-zero");
      end
      if (DIGITS < 1 || DEINT_MAX > pow10(DIGITS)) begin : g_chk_dig
         $error("DIGITS too small for the largest reading");
      end
   endgenerate

   logic                tick;
   phase_e              phase;
   logic                cnt_clr, cnt_inc, lat_ok, lat_ovr;
   logic [4*DIGITS-1:0] count;

   dsadc_prescale #(.DIV(PRESCALE)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   dsadc_phase_ctl #(
      .INT_COUNTS  (INT_COUNTS),
      .DEINT_MAX   (DEINT_MAX),
      .CYCLE_COUNTS(CYCLE_COUNTS)
   ) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .comp_i (comp_i),
      .phase  (phase),
      .ref_neg(ref_neg),
      .cnt_clr(cnt_clr),
      .cnt_inc(cnt_inc),
      .lat_ok (lat_ok),
      .lat_ovr(lat_ovr)
   );

   dsadc_bcd_count #(.DIGITS(DIGITS)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clr),
      .inc  (cnt_inc),
      .value(count)
   );

   assign phase_az    = (phase == PH_AZ);
   assign phase_int   = (phase == PH_INT);
   assign phase_deint = (phase == PH_DEINT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_bcd  <= '0;
         disp_neg  <= 1'b0;
         disp_over <= 1'b0;
      end else if (lat_ok) begin
         disp_bcd  <= count;
         disp_neg  <= ref_neg;
         disp_over <= 1'b0;
      end else if (lat_ovr) begin
         disp_bcd  <= BLANK;
         disp_neg  <= ref_neg;
         disp_over <= 1'b1;
      end
   end
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
   parameter int PRESCALE     = 4,
   parameter int INT_COUNTS   = 1000,
   parameter int DEINT_MAX    = 2000,
   parameter int CYCLE_COUNTS = 4000,
   parameter int DIGITS       = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                phase_az,
   input logic                phase_int,
   input logic                phase_deint,
   input logic                ref_neg,
   input logic [4*DIGITS-1:0] disp_bcd,
   input logic                disp_neg,
   input logic                disp_over
);
   int   int_clk;
   int   cyc_clk;
   logic int_d;
   logic seen;
   logic legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_clk <= 0;
         cyc_clk <= 0;
         int_d   <= 1'b0;
         seen    <= 1'b0;
      end else begin
         int_d   <= phase_int;
         int_clk <= phase_int ? int_clk + 1 : 0;
         if (phase_int && !int_d) begin
            cyc_clk <= 1;
            seen    <= 1'b1;
         end else begin
            cyc_clk <= cyc_clk + 1;
         end
      end
   end

   always_comb begin
      legal = 1'b1;
      for (int d = 0; d < DIGITS; d++)
         if (disp_bcd[4*d+:4] > 4'd9) legal = 1'b0;
   end

   assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({phase_az, phase_int, phase_deint}) == 1);

   assert_int_after_az_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_int) |-> $past(phase_az));

   assert_deint_after_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_deint) |-> $past(phase_int));

   assert_int_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phase_int) |-> (int_clk == INT_COUNTS * PRESCALE));

   assert_cycle_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_int && !int_d && seen) |-> (cyc_clk == CYCLE_COUNTS * PRESCALE));

   assert_ref_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_deint && $past(phase_deint)) |-> $stable(ref_neg));

   assert_digits_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_over |-> legal);

   assert_over_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      disp_over |-> (disp_bcd == {DIGITS{4'hF}}));

   assert_display_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(phase_deint) |-> ($stable(disp_bcd) && $stable(disp_neg) && $stable(disp_over)));
endmodule

bind dsadc_seq dsadc_seq_chk #(
   .PRESCALE    (PRESCALE),
   .INT_COUNTS  (INT_COUNTS),
   .DEINT_MAX   (DEINT_MAX),
   .CYCLE_COUNTS(CYCLE_COUNTS),
   .DIGITS      (DIGITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase_az   (phase_az),
   .phase_int  (phase_int),
   .phase_deint(phase_deint),
   .ref_neg    (ref_neg),
   .disp_bcd   (disp_bcd),
   .disp_neg   (disp_neg),
   .disp_over  (disp_over)
);

// File: tb/dsadc_seq_test.sv
module dsadc_seq_test;
   localparam int P  = 2;
   localparam int NI = 10;
   localparam int ND = 20;
   localparam int NC = 40;
   localparam int DG = 2;
   localparam int NV = 2 * ND + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          comp_i;
   logic          phase_az, phase_int, phase_deint, ref_neg;
   logic [4*DG-1:0] disp_bcd;
   logic          disp_neg, disp_over;

   int h = -(2 * ND + 3);
   int integ = 0;
   int bpre = 0;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign comp_i = (integ > 0);

   dsadc_seq #(
      .PRESCALE(P), .INT_COUNTS(NI), .DEINT_MAX(ND), .CYCLE_COUNTS(NC), .DIGITS(DG)
   ) uut (
      .clk(clk), .rst_n(rst_n), .comp_i(comp_i),
      .phase_az(phase_az), .phase_int(phase_int), .phase_deint(phase_deint),
      .ref_neg(ref_neg), .disp_bcd(disp_bcd), .disp_neg(disp_neg), .disp_over(disp_over)
   );

   // integrator model: one step per count, reference sign chosen by ref_neg
   always @(posedge clk) begin
      if (!rst_n) begin
         bpre  <= 0;
         integ <= 0;
      end else begin
         bpre <= (bpre == P - 1) ? 0 : bpre + 1;
         if (bpre == P - 1) begin
            if (phase_az)       integ <= 0;
            else if (phase_int) integ <= integ + h;
            else if (phase_deint)
               integ <= ref_neg ? integ + 2 * NI : integ - 2 * NI;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [4*DG-1:0] bcd_of(input int k);
      logic [4*DG-1:0] r;
      int p;
      p = 1;
      for (int i = 0; i < DG; i++) begin
         r[4*i+:4] = 4'((k / p) % 10);
         p = p * 10;
      end
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n, int_len, de_len, k, exp_de;
      logic [4*DG-1:0] exp_disp;
      logic exp_neg, exp_over;

      repeat (3) @(negedge clk);
      chk(phase_az && !phase_int && !phase_deint, "R2", "reset phase az",
          {phase_az, phase_int, phase_deint}, 3'b100);
      chk(disp_bcd == '0, "R8", "reset disp_bcd", disp_bcd, 0);
      chk(!disp_neg && !disp_over, "R8", "reset neg/over", {disp_neg, disp_over}, 0);
      rst_n = 1'b1;

      n = 0;
      do begin @(posedge clk); #1; n++; end while (!phase_int);
      chk(n == (NC - NI - ND) * P, "R2", "first auto-zero clocks", n, (NC - NI - ND) * P);

      for (int idx = 0; idx < NV; idx++) begin
         k = ((h < 0 ? -h : h) + 1) / 2;
         int_len = 0;
         do begin @(posedge clk); #1; int_len++; end while (phase_int);
         chk(int_len == NI * P, "R1", "integrate clocks", int_len, NI * P);
         chk(phase_deint && !phase_az && !phase_int, "R2", "integrate then de-integrate",
             {phase_az, phase_int, phase_deint}, 3'b001);
         chk(ref_neg == (h < 0), "R4", "ref_neg select", ref_neg, h < 0);

         de_len = 0;
         do begin @(posedge clk); #1; de_len++; end while (!phase_az);
         exp_de = (k < ND) ? (k + 1) * P : ND * P;
         chk(de_len == exp_de, (k < ND) ? "R5" : "R7", "de-integrate clocks", de_len, exp_de);

         @(negedge clk);
         exp_neg = (h < 0);
         if (k < ND) begin
            exp_disp = bcd_of(k);
            exp_over = 1'b0;
            chk(disp_bcd == exp_disp, "R5", "reading", disp_bcd, exp_disp);
            chk(disp_bcd == exp_disp, "R6", "bcd digits", disp_bcd, exp_disp);
         end else begin
            exp_disp = {DG{4'hF}};
            exp_over = 1'b1;
            chk(disp_bcd == exp_disp, "R7", "overrange pattern", disp_bcd, exp_disp);
         end
         chk(disp_over == exp_over, (k < ND) ? "R5" : "R7", "disp_over", disp_over, exp_over);
         chk(disp_neg == exp_neg, "R4", "disp_neg", disp_neg, exp_neg);

         if (idx < NV - 1) h = h + 2;

         n = 0;
         do begin @(posedge clk); #1; n++; end while (!phase_int);
         chk(int_len + de_len + n == NC * P, "R3", "cycle clocks", int_len + de_len + n, NC * P);
         chk(disp_bcd == exp_disp && disp_over == exp_over && disp_neg == exp_neg,
             "R8", "display held to next cycle", disp_bcd, exp_disp);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule